// File: doc/BRIEF.md
# Instruction Prefetch Pipeline with Fault Tags

This block is the word queue of a processor front end that fetches 16-bit instruction words. It issues prefetch requests at an even word address and takes the returned words into a short pipeline. Stage B holds the word offered to the decoder. Stage A is an overflow slot that catches a word arriving while B is still occupied. Stage C holds the last word the decoder took, which is the word under execution.

Every stage carries a valid bit and a fault bit. The fault bit marks a word whose bus cycle ended with an error. The fault becomes an exception only when that word reaches stage C. A change of flow flushes all three stages and restarts fetching at the new target.

At most one fetch is in flight. Each request carries a generation tag. The tag advances on every flush, so a response that returns after a flush is recognised as stale and dropped.

Top module: `ifetch_pipe`

## Requirements
- R1: After reset every stage is empty, `exc_o` is 0, and the block requests address RESET_ADDR (default 0) with tag 0.
- R2: Only one fetch is outstanding at a time. A request is raised only when no fetch is pending and stage A or stage B is empty. With both stages full, `req_valid_o` is 0.
- R3: The fetch address advances by 2 for each accepted request (`req_valid_o` and `req_ready_i` both 1). A flush loads the address from `target_i`, with bit 0 forced to 0.
- R4: A response is accepted only when a fetch is pending and `rsp_tag_i` equals the current tag. An accepted word enters stage B if B is empty after this cycle's shift, otherwise stage A. Stage A is never valid while stage B is empty.
- R5: On `consume_i` with stage B valid, the word in B moves into C, and in the same cycle the word in A moves into B. Words reach the decoder in address order.
- R6: The fault bit of a word equals the `rsp_err_i` value of its response and travels with the word from stage to stage. `exc_o` is 1 exactly when stage C is valid and faulted. A faulted word in stage B does not raise `exc_o`.
- R7: A flush clears the valid bits of all stages, cancels the pending fetch and advances the tag. A response that still carries the old tag is discarded.
- R8: `consume_i` while stage B is empty has no effect: stage C keeps its word and its valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Change of flow: empty the pipeline and refetch |
| target_i | input | ADDR_W | New fetch address taken on flush |
| req_valid_o | output | 1 | Fetch request valid |
| req_ready_i | input | 1 | Bus accepts the fetch request |
| req_addr_o | output | ADDR_W | Byte address of the requested word |
| req_tag_o | output | TAG_W | Generation tag sent with the request |
| rsp_valid_i | input | 1 | Bus returns a word |
| rsp_tag_i | input | TAG_W | Tag echoed by the bus |
| rsp_data_i | input | WORD_W | Returned instruction word |
| rsp_err_i | input | 1 | Bus cycle ended with an error |
| dec_valid_o | output | 1 | Stage B holds a word for decode |
| dec_word_o | output | WORD_W | Stage B word |
| dec_fault_o | output | 1 | Stage B fault bit |
| consume_i | input | 1 | Decoder takes the stage B word |
| exe_valid_o | output | 1 | Stage C holds a word |
| exe_word_o | output | WORD_W | Stage C word |
| exe_fault_o | output | 1 | Stage C fault bit |
| exc_o | output | 1 | Faulted word has reached execution |

## Verification
Some rules are checked by assertions on every cycle:
- there is never a hole at stage B while A is full;
- no second request is raised while one is pending;
- the address steps by two after each request, and a flush loads the target;
- a consume copies B into C, and a consume with B empty leaves C alone;
- every stage is empty after a flush;
- `exc_o` rises only on the consume of a faulted word.

Other behaviour can only be shown by the bench scenarios:
- the words reach the decoder in the right order after several different targets, including an odd target;
- a word arriving while B is full is parked in A and is not lost;
- the fetch resumes once A drains;
- a stale response held back across a flush is discarded;
- a fault bit stays silent in B and raises the exception only in C.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
    parameter int WORD_W = 16;

    typedef struct packed {
        logic              vld;
        logic              flt;
        logic [WORD_W-1:0] word;
    } slot_t;
endpackage

// File: rtl/ifp_fetch_ctl.sv
module ifp_fetch_ctl #(
    parameter int ADDR_W     = 24,
    parameter int TAG_W      = 2,
    parameter int RESET_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic              slots_full_i,
    input  logic              req_ready_i,
    input  logic              rsp_valid_i,
    input  logic [TAG_W-1:0]  rsp_tag_i,
    output logic              req_valid_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [TAG_W-1:0]  req_tag_o,
    output logic              rsp_take_o
);
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ALIGN_MK = ~ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [TAG_W-1:0]  gen;
        logic              pend;
    } fstate_t;

    fstate_t s_d, s_q;
    logic    fire;

    always_comb begin
        req_valid_o = !s_q.pend && !slots_full_i;
        fire        = req_valid_o && req_ready_i;
        rsp_take_o  = rsp_valid_i && s_q.pend && (rsp_tag_i == s_q.gen) && !flush_i;
        s_d         = s_q;
        if (flush_i) begin
            s_d.addr = target_i & ALIGN_MK;
            s_d.gen  = s_q.gen + TAG_W'(1);
            s_d.pend = 1'b0;
        end else begin
            if (fire) begin
                s_d.addr = s_q.addr + STEP;
                s_d.pend = 1'b1;
            end
            if (rsp_take_o) begin
                s_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.addr <= ADDR_W'(RESET_ADDR) & ALIGN_MK;
            s_q.gen  <= '0;
            s_q.pend <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_addr_o = s_q.addr;
    assign req_tag_o  = s_q.gen;

    // R2: an accepted request blocks any further request in the next cycle
    p_one_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ready_i && !flush_i) |=> !req_valid_o);

    // R3: the address steps by one word per accepted request
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ready_i && !flush_i) |=> (req_addr_o == $past(req_addr_o) + STEP));

    // R3: a flush loads the aligned target
    p_flush_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (req_addr_o == ($past(target_i) & ALIGN_MK)));
endmodule

// File: rtl/ifp_stages.sv
module ifp_stages
    import ifp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              consume_i,
    input  logic              rsp_take_i,
    input  logic [WORD_W-1:0] rsp_data_i,
    input  logic              rsp_err_i,
    output logic              slots_full_o,
    output slot_t             b_o,
    output slot_t             c_o
);
    typedef struct packed {
        slot_t a;
        slot_t b;
        slot_t c;
    } pstate_t;

    pstate_t p_d, p_q;
    slot_t   incoming;

    always_comb begin
        incoming = '{vld: 1'b1, flt: rsp_err_i, word: rsp_data_i};
        p_d      = p_q;
        if (consume_i && p_q.b.vld) begin
            p_d.c = p_q.b;
            p_d.b = p_q.a;
            p_d.a = '0;
        end
        if (rsp_take_i) begin
            if (!p_d.b.vld) begin
                p_d.b = incoming;
            end else begin
                p_d.a = incoming;
            end
        end
        if (flush_i) begin
            p_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign slots_full_o = p_q.a.vld && p_q.b.vld;
    assign b_o          = p_q.b;
    assign c_o          = p_q.c;

    // R4: the overflow slot is only used behind a full decode slot
    p_no_hole_r4: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.a.vld |-> p_q.b.vld);

    // R5: a consume copies the decode word into the execute stage
    p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_i && p_q.b.vld && !flush_i) |=>
            (p_q.c.vld && p_q.c.word == $past(p_q.b.word) && p_q.c.flt == $past(p_q.b.flt)));

    // R7: a flush leaves every stage empty
    p_flush_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!p_q.a.vld && !p_q.b.vld && !p_q.c.vld));

    // R8: a consume with nothing to decode leaves the execute stage alone
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_i && !p_q.b.vld && !flush_i) |=>
            (p_q.c.vld == $past(p_q.c.vld) && p_q.c.word == $past(p_q.c.word)));
endmodule

// File: rtl/ifetch_pipe.sv
module ifetch_pipe
    import ifp_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int TAG_W      = 2,
    parameter int RESET_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] target_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [TAG_W-1:0]  req_tag_o,
    input  logic              rsp_valid_i,
    input  logic [TAG_W-1:0]  rsp_tag_i,
    input  logic [WORD_W-1:0] rsp_data_i,
    input  logic              rsp_err_i,
    output logic              dec_valid_o,
    output logic [WORD_W-1:0] dec_word_o,
    output logic              dec_fault_o,
    input  logic              consume_i,
    output logic              exe_valid_o,
    output logic [WORD_W-1:0] exe_word_o,
    output logic              exe_fault_o,
    output logic              exc_o
);
    logic  slots_full;
    logic  rsp_take;
    slot_t b_slot;
    slot_t c_slot;

    ifp_fetch_ctl #(
        .ADDR_W    (ADDR_W),
        .TAG_W     (TAG_W),
        .RESET_ADDR(RESET_ADDR)
    ) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .target_i    (target_i),
        .slots_full_i(slots_full),
        .req_ready_i (req_ready_i),
        .rsp_valid_i (rsp_valid_i),
        .rsp_tag_i   (rsp_tag_i),
        .req_valid_o (req_valid_o),
        .req_addr_o  (req_addr_o),
        .req_tag_o   (req_tag_o),
        .rsp_take_o  (rsp_take)
    );

    ifp_stages u_stg (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .consume_i   (consume_i),
        .rsp_take_i  (rsp_take),
        .rsp_data_i  (rsp_data_i),
        .rsp_err_i   (rsp_err_i),
        .slots_full_o(slots_full),
        .b_o         (b_slot),
        .c_o         (c_slot)
    );

    assign dec_valid_o = b_slot.vld;
    assign dec_word_o  = b_slot.word;
    assign dec_fault_o = b_slot.flt;
    assign exe_valid_o = c_slot.vld;
    assign exe_word_o  = c_slot.word;
    assign exe_fault_o = c_slot.flt;
    assign exc_o       = c_slot.vld && c_slot.flt;

    // R6: the exception appears only when a faulted decode word is consumed
    p_exc_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exc_o) |-> $past(consume_i && dec_valid_o && dec_fault_o));
endmodule

// File: tb/ifetch_pipe_test.sv
module ifetch_pipe_test;
    localparam int ADDR_W = 24;
    localparam int TAG_W  = 2;
    localparam int WORD_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush_i = 1'b0;
    logic [ADDR_W-1:0] target_i = '0;
    logic              req_valid_o, req_ready_i;
    logic [ADDR_W-1:0] req_addr_o;
    logic [TAG_W-1:0]  req_tag_o;
    logic              rsp_valid_i;
    logic [TAG_W-1:0]  rsp_tag_i;
    logic [WORD_W-1:0] rsp_data_i;
    logic              rsp_err_i;
    logic              dec_valid_o, dec_fault_o;
    logic [WORD_W-1:0] dec_word_o;
    logic              consume_i = 1'b0;
    logic              exe_valid_o, exe_fault_o, exc_o;
    logic [WORD_W-1:0] exe_word_o;

    int n_chk  = 0;
    int n_fail = 0;

    // bus model: one-cycle latency, can be held to stall the response
    logic              hold = 1'b0;
    logic [ADDR_W-1:0] fault_addr = 24'hFFFFFE;
    logic              bus_q;
    logic [ADDR_W-1:0] bus_addr;
    logic [TAG_W-1:0]  bus_tag;

    always #10 clk = ~clk;

    function automatic logic [WORD_W-1:0] dat(input logic [ADDR_W-1:0] a);
        return a[16:1] ^ 16'hC3A5;
    endfunction

    assign req_ready_i = !hold;
    assign rsp_valid_i = bus_q && !hold;
    assign rsp_tag_i   = bus_tag;
    assign rsp_data_i  = dat(bus_addr);
    assign rsp_err_i   = (bus_addr == fault_addr);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q    <= 1'b0;
            bus_addr <= '0;
            bus_tag  <= '0;
        end else if (!(bus_q && hold)) begin
            bus_q    <= req_valid_o && req_ready_i;
            bus_addr <= req_addr_o;
            bus_tag  <= req_tag_o;
        end
    end

    ifetch_pipe uut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .target_i(target_i),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .req_addr_o(req_addr_o), .req_tag_o(req_tag_o),
        .rsp_valid_i(rsp_valid_i), .rsp_tag_i(rsp_tag_i),
        .rsp_data_i(rsp_data_i), .rsp_err_i(rsp_err_i),
        .dec_valid_o(dec_valid_o), .dec_word_o(dec_word_o), .dec_fault_o(dec_fault_o),
        .consume_i(consume_i),
        .exe_valid_o(exe_valid_o), .exe_word_o(exe_word_o), .exe_fault_o(exe_fault_o),
        .exc_o(exc_o)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_flush(input logic [ADDR_W-1:0] t);
        flush_i  = 1'b1;
        target_i = t;
        tick();
        flush_i  = 1'b0;
    endtask

    task automatic do_consume();
        consume_i = 1'b1;
        tick();
        consume_i = 1'b0;
    endtask

    task automatic wait_dec();
        for (int n = 0; n < 50 && !dec_valid_o; n++) tick();
    endtask

    // table: target, words to consume, idle cycles before each consume
    localparam logic [39:0] VECS [4] = '{
        {24'h000100, 8'd5, 8'd0},
        {24'h001FFE, 8'd4, 8'd2},
        {24'h0A0010, 8'd6, 8'd1},
        {24'h000033, 8'd3, 8'd0}
    };

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] last;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 dec_valid", 32'(dec_valid_o), 0);
        check("R1 exe_valid", 32'(exe_valid_o), 0);
        check("R1 exc", 32'(exc_o), 0);
        check("R1 req_valid", 32'(req_valid_o), 1);
        check("R1 req_addr", 32'(req_addr_o), 0);
        check("R1 req_tag", 32'(req_tag_o), 0);
        tick();

        // table walk: R3, R5, R7
        foreach (VECS[v]) begin
            base = VECS[v][39:16] & ~24'd1;
            do_flush(VECS[v][39:16]);
            check("R7 flush empties decode", 32'(dec_valid_o), 0);
            check("R7 flush empties execute", 32'(exe_valid_o), 0);
            check("R3 flush loads aligned target", 32'(req_addr_o), 32'(base));
            for (int i = 0; i < int'(VECS[v][15:8]); i++) begin
                wait_dec();
                check("R5 decode order", 32'(dec_word_o), 32'(dat(base + ADDR_W'(2 * i))));
                check("R6 clean word no fault", 32'(dec_fault_o), 0);
                repeat (int'(VECS[v][7:0])) tick();
                do_consume();
                check("R5 execute word", 32'(exe_word_o), 32'(dat(base + ADDR_W'(2 * i))));
                check("R5 execute valid", 32'(exe_valid_o), 1);
            end
        end

        // overflow slot: R2, R4, R5
        do_flush(24'h000200);
        repeat (10) tick();
        check("R4 decode holds first word", 32'(dec_word_o), 32'(dat(24'h000200)));
        check("R2 no request when full", 32'(req_valid_o), 0);
        check("R2 exactly two words fetched", 32'(req_addr_o), 32'h204);
        do_consume();
        check("R5 overflow word moved same cycle", 32'(dec_valid_o), 1);
        check("R5 overflow word value", 32'(dec_word_o), 32'(dat(24'h000202)));
        check("R5 execute took first", 32'(exe_word_o), 32'(dat(24'h000200)));
        check("R2 request resumes", 32'(req_valid_o), 1);

        // consume with empty decode stage: R8
        do_flush(24'h000300);
        do_consume();
        check("R8 empty consume leaves execute empty", 32'(exe_valid_o), 0);
        wait_dec();
        check("R8 first word not lost", 32'(dec_word_o), 32'(dat(24'h000300)));
        hold = 1'b1;
        last = 24'h000300;
        for (int n = 0; n < 4 && dec_valid_o; n++) begin
            do_consume();
            last = 24'h000300 + ADDR_W'(2 * n);
        end
        check("R8 drained", 32'(dec_valid_o), 0);
        do_consume();
        check("R8 execute valid kept", 32'(exe_valid_o), 1);
        check("R8 execute word kept", 32'(exe_word_o), 32'(dat(last)));
        hold = 1'b0;

        // fault tag: R6
        fault_addr = 24'h000402;
        do_flush(24'h000400);
        wait_dec();
        do_consume();
        check("R6 clean word no exception", 32'(exc_o), 0);
        wait_dec();
        check("R6 faulted word in decode", 32'(dec_word_o), 32'(dat(24'h000402)));
        check("R6 decode fault bit", 32'(dec_fault_o), 1);
        check("R6 no exception at decode", 32'(exc_o), 0);
        do_consume();
        check("R6 execute fault bit", 32'(exe_fault_o), 1);
        check("R6 exception at execute", 32'(exc_o), 1);
        wait_dec();
        do_consume();
        check("R6 exception cleared by next word", 32'(exc_o), 0);
        fault_addr = 24'hFFFFFE;

        // stale response: R7
        do_flush(24'h000500);
        tick();
        hold = 1'b1;
        do_flush(24'h000600);
        tick();
        hold = 1'b0;
        wait_dec();
        check("R7 stale response dropped", 32'(dec_word_o), 32'(dat(24'h000600)));

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule